// File: doc/BRIEF.md
# Self-Modifying Code Snoop Controller

This block keeps a split instruction cache and data cache coherent with each other so that code which rewrites itself is caught. It watches lookup events from both caches. A miss on one side sends a snoop probe to the structures of the other side. The probe results then decide the follow-up sequence.

On the data side the probed structures are the data cache, the store buffer and the writeback buffer. On the instruction side they are the instruction cache, the prefetch cache and the line-fill buffer. Each side returns one hit bit per structure on its response lanes. The data side also returns a modified bit for each lane.

The controller runs one sequence at a time and holds `busy` high while it does so. Depending on the miss direction and the probe result, the sequence may write back a modified line and forward the written line to the instruction cache. It may invalidate lines on one side. It ends with a single `done` cycle whose action code tells the requester how to continue: normal line fill, replay of the instruction read, single non-cacheable data read, or go-ahead for the data write.

Top module: `smc_snoop_ctrl`

## Requirements
- R1: An instruction read hit, a data read hit or a data write hit starts no sequence: no probe is raised on either side and `busy` stays low.
- R2: One cycle after a miss is accepted, exactly one probe strobe is high for one cycle, with `prb_addr` equal to the miss address. An instruction read miss raises `prb_d_vld`. A data read or write miss raises `prb_i_vld`.
- R3: When no probed lane reports a hit, `done` rises in the cycle right after the probe cycle, with action code 0 (line fill). There is no writeback and no invalidate.
- R4: When an instruction-miss probe hits a lane with its modified bit set, `wb_req` is held high until `wb_ack` is seen. `inv_d_vld` is raised only in the cycle after that acknowledge, together with `fwd_vld`, and `done` then carries action code 1 (replay).
- R5: When an instruction-miss probe hits only clean lanes, the cycle after the probe raises `inv_d_vld` with `inv_d_mask` equal to the hit lanes (bit g is data-side lane g), with no writeback and no forwarding. `done` then carries action code 1 (replay).
- R6: When a data read-miss probe hits any instruction-side lane, no invalidate is issued on either side and `done` carries action code 2 (single non-cacheable read) in the cycle after the probe.
- R7: When a data write-miss probe hits, `inv_i_vld` is raised for one cycle with `inv_i_mask` equal to the hit lanes (bit g is instruction-side lane g). `done` follows with action code 3 (write proceeds).
- R8: `busy` is high from the probe cycle through the `done` cycle and low afterwards. Events presented while `busy` is high are ignored.
- R9: When an instruction read miss and a data miss arrive in the same idle cycle, the instruction miss is served and the data miss is ignored.
- R10: While `rst_n` is low, `busy`, both probe strobes, `wb_req`, `fwd_vld`, both invalidate strobes and `done` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ic_ev_vld | input | 1 | Instruction cache lookup event |
| ic_ev_hit | input | 1 | 1 = that lookup hit, 0 = miss |
| ic_ev_addr | input | AW | Address of the instruction lookup |
| dc_ev_vld | input | 1 | Data cache lookup event |
| dc_ev_hit | input | 1 | 1 = that lookup hit, 0 = miss |
| dc_ev_wr | input | 1 | 1 = write access, 0 = read access |
| dc_ev_addr | input | AW | Address of the data lookup |
| busy | output | 1 | A snoop sequence is running; requesters stall |
| prb_d_vld | output | 1 | Probe strobe to the data-side structures |
| prb_i_vld | output | 1 | Probe strobe to the instruction-side structures |
| prb_addr | output | AW | Probed line address |
| d_rsp_hit | input | NDS | Data-side hit per lane, valid in the probe cycle |
| d_rsp_dirty | input | NDS | Data-side modified bit per lane, valid in the probe cycle |
| i_rsp_hit | input | NIS | Instruction-side hit per lane, valid in the probe cycle |
| wb_req | output | 1 | Write back the modified line at `prb_addr` |
| wb_ack | input | 1 | Writeback complete |
| fwd_vld | output | 1 | Written-back line is passed to the instruction cache |
| inv_d_vld | output | 1 | Invalidate strobe for the data side |
| inv_d_mask | output | NDS | Data-side lanes to invalidate |
| inv_i_vld | output | 1 | Invalidate strobe for the instruction side |
| inv_i_mask | output | NIS | Instruction-side lanes to invalidate |
| done | output | 1 | One-cycle end-of-sequence strobe |
| done_act | output | 2 | 0 fill, 1 replay instruction read, 2 non-cacheable data read, 3 write proceeds |

## Verification
The checker assumes several things about the surroundings. The response lanes are meaningful only in the probe cycle. `wb_ack` is raised only while `wb_req` is high, since the forward check traces `fwd_vld` back to an acknowledged writeback. A requester whose event was ignored re-presents it later. The bench keeps to these rules. It drives hit and modified lanes only in the cycle it sees a probe and clears them on the next falling edge. It raises `wb_ack` for a single cycle, and only after counting the requested number of cycles with `wb_req` visible. All stimulus changes on the falling edge.

// File: rtl/smc_pkg.sv
package smc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PROBE = 3'd1,
    ST_WB    = 3'd2,
    ST_INV   = 3'd3,
    ST_DONE  = 3'd4
  } smc_st_e;

  typedef enum logic [1:0] {
    KD_IMISS = 2'd0,
    KD_DRD   = 2'd1,
    KD_DWR   = 2'd2
  } smc_kind_e;

  typedef enum logic [1:0] {
    ACT_FILL     = 2'd0,
    ACT_REPLAY   = 2'd1,
    ACT_UNCACHED = 2'd2,
    ACT_WRITE    = 2'd3
  } smc_act_e;
endpackage

// File: rtl/smc_req_sel.sv
module smc_req_sel
  import smc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          busy,
  input  logic          ic_vld,
  input  logic          ic_hit,
  input  logic [AW-1:0] ic_addr,
  input  logic          dc_vld,
  input  logic          dc_hit,
  input  logic          dc_wr,
  input  logic [AW-1:0] dc_addr,
  output logic          start,
  output smc_kind_e     kind,
  output logic [AW-1:0] addr
);
  logic ic_miss, dc_miss;

  assign ic_miss = ic_vld & ~ic_hit;
  assign dc_miss = dc_vld & ~dc_hit;

  // instruction misses win a tie; nothing is taken while a sequence runs
  always_comb begin
    start = 1'b0;
    kind  = KD_IMISS;
    addr  = ic_addr;
    if (!busy) begin
      if (ic_miss) begin
        start = 1'b1;
      end else if (dc_miss) begin
        start = 1'b1;
        kind  = dc_wr ? KD_DWR : KD_DRD;
        addr  = dc_addr;
      end
    end
  end
endmodule

// File: rtl/smc_hit_eval.sv
module smc_hit_eval
  import smc_pkg::*;
#(
  parameter int NDS = 3,
  parameter int NIS = 3,
  parameter int MW  = 3
) (
  input  smc_kind_e        kind,
  input  logic [NDS-1:0]   d_hit,
  input  logic [NDS-1:0]   d_dirty,
  input  logic [NIS-1:0]   i_hit,
  output logic [MW-1:0]    hit_mask,
  output logic             any_hit,
  output logic             any_dirty
);
  logic [MW-1:0] d_lane, dd_lane, i_lane;

  for (genvar g = 0; g < MW; g++) begin : g_lane
    if (g < NDS) begin : g_d
      assign d_lane[g]  = d_hit[g];
      assign dd_lane[g] = d_hit[g] & d_dirty[g];
    end else begin : g_dz
      assign d_lane[g]  = 1'b0;
      assign dd_lane[g] = 1'b0;
    end
    if (g < NIS) begin : g_i
      assign i_lane[g] = i_hit[g];
    end else begin : g_iz
      assign i_lane[g] = 1'b0;
    end
  end

  assign hit_mask  = (kind == KD_IMISS) ? d_lane : i_lane;
  assign any_hit   = |hit_mask;
  assign any_dirty = (kind == KD_IMISS) & (|dd_lane);
endmodule

// File: rtl/smc_seq_fsm.sv
module smc_seq_fsm
  import smc_pkg::*;
#(
  parameter int AW = 32,
  parameter int MW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  smc_kind_e     kind_in,
  input  logic [AW-1:0] addr_in,
  input  logic [MW-1:0] hit_mask,
  input  logic          any_hit,
  input  logic          any_dirty,
  input  logic          wb_ack,
  output logic          busy,
  output smc_kind_e     kind_q,
  output logic [AW-1:0] addr_q,
  output logic [MW-1:0] hmask_q,
  output logic          prb_vld,
  output logic          wb_req,
  output logic          inv_vld,
  output logic          fwd_vld,
  output logic          done,
  output smc_act_e      act_q
);
  smc_st_e  st_q, st_d;
  smc_act_e act_d;
  logic     req_en, hit_en, fwd_d, fwd_q;

  assign req_en = start;
  assign hit_en = (st_q == ST_PROBE);
  assign fwd_d  = (st_q == ST_WB) & wb_ack;

  always_comb begin
    st_d  = st_q;
    act_d = act_q;
    case (st_q)
      ST_IDLE:  if (start) st_d = ST_PROBE;
      ST_PROBE: begin
        unique case (kind_q)
          KD_IMISS: begin
            act_d = any_hit ? ACT_REPLAY : ACT_FILL;
            st_d  = !any_hit ? ST_DONE : (any_dirty ? ST_WB : ST_INV);
          end
          KD_DRD: begin
            act_d = any_hit ? ACT_UNCACHED : ACT_FILL;
            st_d  = ST_DONE;
          end
          default: begin
            act_d = any_hit ? ACT_WRITE : ACT_FILL;
            st_d  = any_hit ? ST_INV : ST_DONE;
          end
        endcase
      end
      ST_WB:   if (wb_ack) st_d = ST_INV;
      ST_INV:  st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      fwd_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      fwd_q <= fwd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= KD_IMISS;
      addr_q <= '0;
    end else if (req_en) begin
      kind_q <= kind_in;
      addr_q <= addr_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hmask_q <= '0;
      act_q   <= ACT_FILL;
    end else if (hit_en) begin
      hmask_q <= hit_mask;
      act_q   <= act_d;
    end
  end

  assign busy    = (st_q != ST_IDLE);
  assign prb_vld = (st_q == ST_PROBE);
  assign wb_req  = (st_q == ST_WB);
  assign inv_vld = (st_q == ST_INV);
  assign fwd_vld = fwd_q;
  assign done    = (st_q == ST_DONE);
endmodule

// File: rtl/smc_snoop_ctrl.sv
module smc_snoop_ctrl
  import smc_pkg::*;
#(
  parameter int AW  = 32,
  parameter int NDS = 3,
  parameter int NIS = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ic_ev_vld,
  input  logic           ic_ev_hit,
  input  logic [AW-1:0]  ic_ev_addr,
  input  logic           dc_ev_vld,
  input  logic           dc_ev_hit,
  input  logic           dc_ev_wr,
  input  logic [AW-1:0]  dc_ev_addr,
  output logic           busy,
  output logic           prb_d_vld,
  output logic           prb_i_vld,
  output logic [AW-1:0]  prb_addr,
  input  logic [NDS-1:0] d_rsp_hit,
  input  logic [NDS-1:0] d_rsp_dirty,
  input  logic [NIS-1:0] i_rsp_hit,
  output logic           wb_req,
  input  logic           wb_ack,
  output logic           fwd_vld,
  output logic           inv_d_vld,
  output logic [NDS-1:0] inv_d_mask,
  output logic           inv_i_vld,
  output logic [NIS-1:0] inv_i_mask,
  output logic           done,
  output logic [1:0]     done_act
);
  localparam int MW = (NDS > NIS) ? NDS : NIS;

  logic          start, any_hit, any_dirty, prb_vld, inv_vld, is_imiss;
  smc_kind_e     sel_kind, kind_q;
  smc_act_e      act_q;
  logic [AW-1:0] sel_addr;
  logic [MW-1:0] hit_mask, hmask_q;

  smc_req_sel #(.AW(AW)) u_sel (
    .busy   (busy),
    .ic_vld (ic_ev_vld),
    .ic_hit (ic_ev_hit),
    .ic_addr(ic_ev_addr),
    .dc_vld (dc_ev_vld),
    .dc_hit (dc_ev_hit),
    .dc_wr  (dc_ev_wr),
    .dc_addr(dc_ev_addr),
    .start  (start),
    .kind   (sel_kind),
    .addr   (sel_addr)
  );

  smc_hit_eval #(.NDS(NDS), .NIS(NIS), .MW(MW)) u_eval (
    .kind     (kind_q),
    .d_hit    (d_rsp_hit),
    .d_dirty  (d_rsp_dirty),
    .i_hit    (i_rsp_hit),
    .hit_mask (hit_mask),
    .any_hit  (any_hit),
    .any_dirty(any_dirty)
  );

  smc_seq_fsm #(.AW(AW), .MW(MW)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .kind_in  (sel_kind),
    .addr_in  (sel_addr),
    .hit_mask (hit_mask),
    .any_hit  (any_hit),
    .any_dirty(any_dirty),
    .wb_ack   (wb_ack),
    .busy     (busy),
    .kind_q   (kind_q),
    .addr_q   (prb_addr),
    .hmask_q  (hmask_q),
    .prb_vld  (prb_vld),
    .wb_req   (wb_req),
    .inv_vld  (inv_vld),
    .fwd_vld  (fwd_vld),
    .done     (done),
    .act_q    (act_q)
  );

  assign is_imiss   = (kind_q == KD_IMISS);
  assign prb_d_vld  = prb_vld & is_imiss;
  assign prb_i_vld  = prb_vld & ~is_imiss;
  assign inv_d_vld  = inv_vld & is_imiss;
  assign inv_i_vld  = inv_vld & ~is_imiss;
  assign inv_d_mask = inv_d_vld ? hmask_q[NDS-1:0] : '0;
  assign inv_i_mask = inv_i_vld ? hmask_q[NIS-1:0] : '0;
  assign done_act   = act_q;
endmodule

// File: rtl/smc_snoop_chk.sv
module smc_snoop_chk
  import smc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       ic_ev_vld,
  input logic       ic_ev_hit,
  input logic       dc_ev_vld,
  input logic       dc_ev_hit,
  input logic       busy,
  input logic       prb_d_vld,
  input logic       prb_i_vld,
  input logic       wb_req,
  input logic       wb_ack,
  input logic       fwd_vld,
  input logic       inv_d_vld,
  input logic       inv_i_vld,
  input logic       done,
  input logic [1:0] done_act
);
  p_hit_no_probe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(ic_ev_vld && !ic_ev_hit) && !(dc_ev_vld && !dc_ev_hit))
      |=> (!prb_d_vld && !prb_i_vld));

  p_one_side_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(prb_d_vld && prb_i_vld));

  p_fill_after_probe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_act == 2'(ACT_FILL)) |-> $past(prb_d_vld || prb_i_vld));

  p_wb_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && !wb_ack) |=> (wb_req && !inv_d_vld));

  p_fwd_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_vld |-> ($past(wb_req && wb_ack) && inv_d_vld));

  p_replay_after_inv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_act == 2'(ACT_REPLAY)) |-> $past(inv_d_vld));

  p_uncached_no_inv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_act == 2'(ACT_UNCACHED)) |-> ($past(prb_i_vld) && !$past(inv_i_vld)));

  p_write_after_inv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_act == 2'(ACT_WRITE)) |-> $past(inv_i_vld));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!prb_d_vld && !prb_i_vld && !wb_req && !inv_d_vld && !inv_i_vld && !done));

  p_done_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

bind smc_snoop_ctrl smc_snoop_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ic_ev_vld(ic_ev_vld),
  .ic_ev_hit(ic_ev_hit),
  .dc_ev_vld(dc_ev_vld),
  .dc_ev_hit(dc_ev_hit),
  .busy     (busy),
  .prb_d_vld(prb_d_vld),
  .prb_i_vld(prb_i_vld),
  .wb_req   (wb_req),
  .wb_ack   (wb_ack),
  .fwd_vld  (fwd_vld),
  .inv_d_vld(inv_d_vld),
  .inv_i_vld(inv_i_vld),
  .done     (done),
  .done_act (done_act)
);

// File: tb/smc_snoop_ctrl_tb.sv
module smc_snoop_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int NDS = 3;
  localparam int NIS = 3;

  // vector: [13:12] kind (0 instr miss, 1 data read miss, 2 data write miss),
  // [11:9] hit lanes, [8:6] modified lanes, [5:4] action, [3] writeback, [2:0] inv lanes
  localparam int NV = 8;
  localparam logic [13:0] VEC [NV] = '{
    {2'd0, 3'b000, 3'b000, 2'd0, 1'b0, 3'b000},
    {2'd0, 3'b001, 3'b000, 2'd1, 1'b0, 3'b001},
    {2'd0, 3'b011, 3'b010, 2'd1, 1'b1, 3'b011},
    {2'd0, 3'b100, 3'b100, 2'd1, 1'b1, 3'b100},
    {2'd1, 3'b000, 3'b000, 2'd0, 1'b0, 3'b000},
    {2'd1, 3'b110, 3'b000, 2'd2, 1'b0, 3'b000},
    {2'd2, 3'b000, 3'b000, 2'd0, 1'b0, 3'b000},
    {2'd2, 3'b101, 3'b000, 2'd3, 1'b0, 3'b101}
  };

  logic clk, rst_n;
  logic ic_ev_vld, ic_ev_hit, dc_ev_vld, dc_ev_hit, dc_ev_wr;
  logic [AW-1:0] ic_ev_addr, dc_ev_addr, prb_addr;
  logic busy, prb_d_vld, prb_i_vld, wb_req, wb_ack, fwd_vld;
  logic [NDS-1:0] d_rsp_hit, d_rsp_dirty, inv_d_mask;
  logic [NIS-1:0] i_rsp_hit, inv_i_mask;
  logic inv_d_vld, inv_i_vld, done;
  logic [1:0] done_act;

  int n_chk, n_bad;
  logic [AW-1:0] addr_ctr;

  smc_snoop_ctrl #(.AW(AW), .NDS(NDS), .NIS(NIS)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .ic_ev_vld(ic_ev_vld), .ic_ev_hit(ic_ev_hit), .ic_ev_addr(ic_ev_addr),
    .dc_ev_vld(dc_ev_vld), .dc_ev_hit(dc_ev_hit), .dc_ev_wr(dc_ev_wr), .dc_ev_addr(dc_ev_addr),
    .busy(busy), .prb_d_vld(prb_d_vld), .prb_i_vld(prb_i_vld), .prb_addr(prb_addr),
    .d_rsp_hit(d_rsp_hit), .d_rsp_dirty(d_rsp_dirty), .i_rsp_hit(i_rsp_hit),
    .wb_req(wb_req), .wb_ack(wb_ack), .fwd_vld(fwd_vld),
    .inv_d_vld(inv_d_vld), .inv_d_mask(inv_d_mask),
    .inv_i_vld(inv_i_vld), .inv_i_mask(inv_i_mask),
    .done(done), .done_act(done_act)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ic_ev_vld = 0; ic_ev_hit = 0; dc_ev_vld = 0; dc_ev_hit = 0; dc_ev_wr = 0;
    d_rsp_hit = '0; d_rsp_dirty = '0; i_rsp_hit = '0; wb_ack = 0;
  endtask

  task automatic run_seq(input int kind, input logic [2:0] hit, input logic [2:0] dirty,
                         input logic [1:0] eact, input logic ewb, input logic [2:0] einv,
                         input int ackdly, input string tag);
    logic [AW-1:0] a;
    logic [2:0] seen_d, seen_i;
    bit saw_wb, acked, saw_done;
    int wbcnt, ndone;
    seen_d = 0; seen_i = 0; saw_wb = 0; acked = 0; saw_done = 0; wbcnt = 0; ndone = 0;
    addr_ctr = addr_ctr + 32'h0001_0040;
    a = addr_ctr;
    @(negedge clk);
    if (kind == 0) begin
      ic_ev_vld = 1; ic_ev_hit = 0; ic_ev_addr = a;
    end else begin
      dc_ev_vld = 1; dc_ev_hit = 0; dc_ev_wr = (kind == 2); dc_ev_addr = a;
    end
    @(negedge clk);
    ic_ev_vld = 0; dc_ev_vld = 0;
    // R2: probe one cycle after the accepted miss
    chk(prb_d_vld == (kind == 0) && prb_i_vld == (kind != 0), "R2", "probe side",
        {prb_d_vld, prb_i_vld}, (kind == 0) ? 2 : 1);
    chk(prb_addr == a, "R2", "probe address", prb_addr, a);
    chk(busy == 1'b1, "R8", "busy in probe cycle", busy, 1);
    if (kind == 0) begin d_rsp_hit = hit; d_rsp_dirty = dirty; end
    else i_rsp_hit = hit;
    for (int n = 1; n <= 40; n++) begin
      @(negedge clk);
      d_rsp_hit = '0; d_rsp_dirty = '0; i_rsp_hit = '0; wb_ack = 0;
      if (inv_d_vld || inv_i_vld) begin
        seen_d = seen_d | inv_d_mask;
        seen_i = seen_i | inv_i_mask;
        chk(!ewb || acked, "R4", "invalidate before writeback acknowledge", acked, 1);
        chk(fwd_vld == ewb, "R4", "forward with invalidate", fwd_vld, ewb);
      end
      if (wb_req) begin
        saw_wb = 1;
        chk(!inv_d_vld, "R4", "invalidate during writeback", inv_d_vld, 0);
        wbcnt++;
        if (wbcnt > ackdly) begin wb_ack = 1; acked = 1; end
      end
      if (done) begin
        saw_done = 1; ndone = n;
        chk(busy, "R8", "busy in done cycle", busy, 1);
        chk(done_act == eact, tag, "action code", done_act, eact);
        break;
      end
    end
    chk(saw_done, tag, "sequence finished", saw_done, 1);
    chk(saw_wb == ewb, "R4", "writeback issued", saw_wb, ewb);
    if (kind == 0) chk(seen_d == einv && seen_i == 0, tag, "invalidate lanes",
                       {seen_d, seen_i}, {einv, 3'b000});
    else chk(seen_i == einv && seen_d == 0, tag, "invalidate lanes",
             {seen_i, seen_d}, {einv, 3'b000});
    if (eact == 2'd0) chk(ndone == 1, "R3", "fill latency after probe", ndone, 1);
    if (eact == 2'd2) chk(ndone == 1, "R6", "uncached latency after probe", ndone, 1);
    @(negedge clk);
    chk(!busy, "R8", "busy after done", busy, 0);
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    n_chk = 0; n_bad = 0; addr_ctr = 32'h1000;
    idle_inputs();
    ic_ev_addr = '0; dc_ev_addr = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!busy && !prb_d_vld && !prb_i_vld && !wb_req && !fwd_vld && !inv_d_vld
        && !inv_i_vld && !done, "R10", "outputs in reset",
        {busy, prb_d_vld, prb_i_vld, wb_req, fwd_vld, inv_d_vld, inv_i_vld, done}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      string tag;
      case (VEC[v][5:4])
        2'd0: tag = "R3";
        2'd1: tag = VEC[v][3] ? "R4" : "R5";
        2'd2: tag = "R6";
        default: tag = "R7";
      endcase
      run_seq(int'(VEC[v][13:12]), VEC[v][11:9], VEC[v][8:6], VEC[v][5:4],
              VEC[v][3], VEC[v][2:0], v % 3, tag);
    end

    // R4: slow acknowledge, several modified lanes
    run_seq(0, 3'b111, 3'b101, 2'd1, 1'b1, 3'b111, 5, "R4");

    // R1: hits start nothing
    @(negedge clk);
    ic_ev_vld = 1; ic_ev_hit = 1; ic_ev_addr = 32'hAA00;
    @(negedge clk);
    chk(!busy && !prb_d_vld && !prb_i_vld, "R1", "instr hit probe",
        {busy, prb_d_vld, prb_i_vld}, 0);
    ic_ev_vld = 0; dc_ev_vld = 1; dc_ev_hit = 1; dc_ev_wr = 0;
    @(negedge clk);
    chk(!busy && !prb_d_vld && !prb_i_vld, "R1", "data read hit probe",
        {busy, prb_d_vld, prb_i_vld}, 0);
    dc_ev_wr = 1;
    @(negedge clk);
    chk(!busy && !prb_d_vld && !prb_i_vld, "R1", "data write hit probe",
        {busy, prb_d_vld, prb_i_vld}, 0);
    idle_inputs();
    @(negedge clk);
    chk(!busy, "R1", "still idle", busy, 0);

    // R8: data miss presented while busy is ignored
    ic_ev_vld = 1; ic_ev_hit = 0; ic_ev_addr = 32'hBB40;
    @(negedge clk);
    ic_ev_vld = 0;
    d_rsp_hit = 3'b010;
    dc_ev_vld = 1; dc_ev_hit = 0; dc_ev_wr = 1; dc_ev_addr = 32'hCC80;
    @(negedge clk);
    d_rsp_hit = '0;
    chk(inv_d_vld && inv_d_mask == 3'b010, "R5", "clean hit invalidate",
        {inv_d_vld, inv_d_mask}, 4'b1010);
    @(negedge clk);
    chk(done && done_act == 2'd1, "R5", "replay after clean hit", {done, done_act}, 3'b101);
    dc_ev_vld = 0;
    @(negedge clk);
    chk(!busy && !prb_i_vld, "R8", "event during busy dropped", {busy, prb_i_vld}, 0);

    // R9: simultaneous misses, instruction side served
    ic_ev_vld = 1; ic_ev_hit = 0; ic_ev_addr = 32'hDD00;
    dc_ev_vld = 1; dc_ev_hit = 0; dc_ev_wr = 0; dc_ev_addr = 32'hEE00;
    @(negedge clk);
    ic_ev_vld = 0; dc_ev_vld = 0;
    chk(prb_d_vld && !prb_i_vld && prb_addr == 32'hDD00, "R9", "instruction miss wins",
        {prb_d_vld, prb_i_vld, prb_addr}, {2'b10, 32'hDD00});
    @(negedge clk);
    chk(done && done_act == 2'd0, "R9", "fill on no hit", {done, done_act}, 3'b100);
    @(negedge clk);
    chk(!busy && !prb_i_vld, "R9", "data miss not served", {busy, prb_i_vld}, 0);

    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule